// File: doc/BRIEF.md
# Multichannel audio serial receiver

This block captures serial PCM audio from one to three data pins and turns it into 32-bit words in a small receive queue. A bit clock marks each data bit and a word-select clock marks which channel of a pair the current bits belong to (low for left, high for right). The block can generate both clocks itself (master) or follow clocks driven from outside (slave). In slave mode the clocks and data pass through two-flop synchronisers and all edges are found in the system clock domain. In master mode the generated clocks go through the same synchronisers, so both modes share one capture path.

Once the run input is set, nothing is captured until a word-select fall marks the start of a left sample. From then on, every word-select transition completes one sample per enabled data pin. In the 16-bit format a left sample is held until its right partner arrives, and the pair is written as one word. In the 17-to-24-bit format every sample becomes its own word. A downstream reader pops words while the service request is high. A write into a full queue is dropped and reported.

Top module: `aud_rx`

## Requirements
- R1: After run_i rises, no word is written until a falling edge of the word-select clock (the start of a left sample) is seen. Bits and word-select edges seen earlier are ignored.
- R2: Data is sampled on rising bit-clock edges, MSB first. The first bit of a sample is taken on the second rising edge after a word-select transition. Bits beyond the configured width are ignored.
- R3: With wide_i=0, each enabled pin yields one word per left/right pair: bits [31:16] hold the right sample and bits [15:0] hold the left sample.
- R4: With wide_i=1, each sample is a word of width_i bits (clamped to 17..24), right-justified from bit 0 and zero above. Left words are written at the left-to-right boundary and right words at the following right-to-left boundary.
- R5: pairs_i selects 1 to 3 pairs (0 is treated as 1) on sdata_i[pairs-1:0]. The words of one boundary are written in ascending pin order, so in the wide format all left words precede all right words.
- R6: A word arriving at a full queue is discarded and the contents are unchanged. The drop sets ovf_o (sticky) and pulses ovf_irq_o for one cycle. ovf_o clears when a new run starts from idle.
- R7: dreq_o is high exactly while the queue holds at least one word. rdata_o shows the oldest word, and rd_i removes it.
- R8: After run_i is cleared, capture continues to the next left-sample boundary. The right samples that complete there are still written, and nothing after them is. In master mode the clocks then rest with bclk_o low and lrck_o high.
- R9: In master mode bclk_o has a period of 2*DIV system cycles. lrck_o starts high and toggles on a bclk_o fall after every SLOT bit periods, so the first left boundary follows SLOT rising edges.
- R10: In slave mode, with the external clocks not toggling, no word is written even while run_i is set.
- R11: After reset, dreq_o, ovf_o, ovf_irq_o and bclk_o are low and lrck_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start capture / request stop at next left boundary |
| master_i | input | 1 | 1: generate clocks, 0: follow external clocks |
| wide_i | input | 1 | 0: 16-bit packed pairs, 1: one word per sample |
| width_i | input | 5 | Sample width in wide format (17..24) |
| pairs_i | input | 2 | Number of enabled channel pairs (1..3) |
| bclk_i | input | 1 | External bit clock (slave) |
| lrck_i | input | 1 | External word-select clock (slave) |
| sdata_i | input | 3 | Serial data, one pin per channel pair |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrck_o | output | 1 | Generated word-select clock (master) |
| rd_i | input | 1 | Pop the oldest queue word |
| rdata_o | output | 32 | Oldest queue word |
| dreq_o | output | 1 | Service request: queue not empty |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_irq_o | output | 1 | One-cycle pulse per dropped word |

## Verification
The hardest case to reach is a stop request that lands in the middle of a left slot. The capture must carry on through the rest of that frame, write its pair, and then ignore a whole further frame. The bench gets there by running the serial driver and a timed run_i clear in parallel, with the clear placed ten bits into the second frame. A second hard case is overflow on the very word that splits a frame. Three pairs of wide samples are fed with the reader held off, so the queue fills partway through the second frame's left words.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_RUN  = 2'd2
  } rx_state_e;

  localparam int PACK_W = 16;
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/aud_rx_clkgen.sv
module aud_rx_clkgen #(
  parameter int DIV  = 4,
  parameter int SLOT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic bclk_o,
  output logic lrck_o
);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BCW = $clog2(SLOT);

  logic [DCW-1:0] div_cnt;
  logic [BCW-1:0] bit_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      bit_cnt <= '0;
      bclk_o  <= 1'b0;
      lrck_o  <= 1'b1;
    end else if (!en_i) begin
      div_cnt <= '0;
      bit_cnt <= '0;
      bclk_o  <= 1'b0;
      lrck_o  <= 1'b1;
    end else if (div_cnt == DCW'(DIV - 1)) begin
      div_cnt <= '0;
      bclk_o  <= ~bclk_o;
      if (bclk_o) begin
        // word select moves only on a falling bit clock
        if (bit_cnt == BCW'(SLOT - 1)) begin
          bit_cnt <= '0;
          lrck_o  <= ~lrck_o;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  AST_CLK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bclk_o && lrck_o)); // R8

  AST_LR_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(lrck_o)) |-> $fell(bclk_o)); // R9
endmodule

// File: rtl/aud_rx_fifo.sv
module aud_rx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          do_wr, do_rd;

  assign full_o  = (cnt == (AW+1)'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign rdata_o = mem[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      cnt <= cnt + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wptr] <= wdata_i;
  end

  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i) |=> (cnt == $past(cnt))); // R6

  AST_POP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_o && !wr_i) |=> (cnt == $past(cnt) - 1'b1)); // R7
endmodule

// File: rtl/aud_rx.sv
module aud_rx #(
  parameter int NPAIR = 3,
  parameter int MAXW  = 24,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int DIV   = 4,
  parameter int SLOT  = 32,
  localparam int CW   = $clog2(MAXW + 1),
  localparam int PW   = $clog2(NPAIR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             master_i,
  input  logic             wide_i,
  input  logic [CW-1:0]    width_i,
  input  logic [PW-1:0]    pairs_i,
  input  logic             bclk_i,
  input  logic             lrck_i,
  input  logic [NPAIR-1:0] sdata_i,
  output logic             bclk_o,
  output logic             lrck_o,
  input  logic             rd_i,
  output logic [DW-1:0]    rdata_o,
  output logic             dreq_o,
  output logic             ovf_o,
  output logic             ovf_irq_o
);
  import aud_rx_pkg::*;

  localparam int SW = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  rx_state_e        st;
  logic             gen_en, gen_bclk, gen_lrck;
  logic [NPAIR+1:0] raw, syn;
  logic             bclk_s, lr_s, bclk_d, lr_prev, bit_ev;
  logic [NPAIR-1:0] dat_s, mask, pend_mask;
  logic [CW-1:0]    eff_w, cnt;
  logic [PW-1:0]    np;
  logic [MAXW-1:0]  sh [NPAIR];
  logic [PACK_W-1:0] lhold [NPAIR];
  logic [DW-1:0]    pend_word [NPAIR];
  logic             push, fifo_full, fifo_empty, drop;
  logic [SW-1:0]    sel;

  assign gen_en = master_i && (st != ST_IDLE);

  aud_rx_clkgen #(.DIV(DIV), .SLOT(SLOT)) u_clkgen (
    .clk_i, .rst_ni, .en_i(gen_en), .bclk_o(gen_bclk), .lrck_o(gen_lrck)
  );
  assign bclk_o = gen_bclk;
  assign lrck_o = gen_lrck;

  // both modes share the synchronised capture path
  assign raw = {master_i ? gen_bclk : bclk_i, master_i ? gen_lrck : lrck_i, sdata_i};

  aud_rx_sync #(.W(NPAIR + 2)) u_sync (.clk_i, .rst_ni, .d_i(raw), .q_o(syn));

  assign bclk_s = syn[NPAIR+1];
  assign lr_s   = syn[NPAIR];
  assign dat_s  = syn[NPAIR-1:0];
  assign bit_ev = bclk_s && !bclk_d;

  always_comb begin
    if (!wide_i)                          eff_w = CW'(PACK_W);
    else if (width_i < CW'(PACK_W + 1))   eff_w = CW'(PACK_W + 1);
    else if (width_i > CW'(MAXW))         eff_w = CW'(MAXW);
    else                                  eff_w = width_i;
    if (pairs_i == '0)                    np = PW'(1);
    else if (pairs_i > PW'(NPAIR))        np = PW'(NPAIR);
    else                                  np = pairs_i;
    for (int p = 0; p < NPAIR; p++) mask[p] = (p < int'(np));
  end

  // one queued word per cycle, lowest pin first
  always_comb begin
    push = 1'b0;
    sel  = '0;
    for (int p = 0; p < NPAIR; p++) begin
      if (pend_mask[p] && !push) begin
        push = 1'b1;
        sel  = SW'(p);
      end
    end
  end

  assign drop = push && fifo_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      bclk_d    <= 1'b0;
      lr_prev   <= 1'b0;
      cnt       <= '0;
      pend_mask <= '0;
      for (int p = 0; p < NPAIR; p++) begin
        sh[p]        <= '0;
        lhold[p]     <= '0;
        pend_word[p] <= '0;
      end
    end else begin
      bclk_d <= bclk_s;
      if (bit_ev) lr_prev <= lr_s;
      if (push) pend_mask[sel] <= 1'b0;
      unique case (st)
        ST_IDLE: if (run_i) st <= ST_SYNC;
        ST_SYNC: begin
          if (!run_i) st <= ST_IDLE;
          else if (bit_ev && lr_prev && !lr_s) begin
            st  <= ST_RUN;
            cnt <= '0;
            for (int p = 0; p < NPAIR; p++) sh[p] <= '0;
          end
        end
        ST_RUN: if (bit_ev) begin
          if (lr_s != lr_prev) begin
            cnt <= '0;
            for (int p = 0; p < NPAIR; p++) sh[p] <= '0;
            if (!lr_prev) begin
              if (wide_i) begin
                for (int p = 0; p < NPAIR; p++) pend_word[p] <= DW'(sh[p]);
                pend_mask <= mask;
              end else begin
                for (int p = 0; p < NPAIR; p++) lhold[p] <= sh[p][PACK_W-1:0];
              end
            end else begin
              for (int p = 0; p < NPAIR; p++)
                pend_word[p] <= wide_i ? DW'(sh[p]) : DW'({sh[p][PACK_W-1:0], lhold[p]});
              pend_mask <= mask;
              if (!run_i) st <= ST_IDLE;
            end
          end else if (cnt < eff_w) begin
            for (int p = 0; p < NPAIR; p++) sh[p] <= {sh[p][MAXW-2:0], dat_s[p]};
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o     <= 1'b0;
      ovf_irq_o <= 1'b0;
    end else begin
      ovf_irq_o <= drop;
      if (drop) ovf_o <= 1'b1;
      else if (st == ST_IDLE && run_i) ovf_o <= 1'b0;
    end
  end

  aud_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .wr_i(push), .wdata_i(pend_word[sel]), .rd_i,
    .rdata_o, .full_o(fifo_full), .empty_o(fifo_empty)
  );
  assign dreq_o = !fifo_empty;

  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && fifo_full) |=> (ovf_o && ovf_irq_o)); // R6

  AST_PUSH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !fifo_full) |=> dreq_o); // R7
endmodule

// File: tb/aud_rx_tb.sv
module aud_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        run_i = 0, master_i = 0, wide_i = 0, rd_i = 0;
  logic [4:0]  width_i = 5'd24;
  logic [1:0]  pairs_i = 2'd1;
  logic        bclk_t = 0, lrck_t = 0;
  logic [2:0]  dat_t = 0;
  logic        codec_bit = 0;
  logic [2:0]  sdata_i;
  logic        bclk_o, lrck_o, dreq_o, ovf_o, ovf_irq_o;
  logic [31:0] rdata_o;

  assign sdata_i = master_i ? {2'b00, codec_bit} : dat_t;

  aud_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i, .master_i, .wide_i, .width_i, .pairs_i,
    .bclk_i(bclk_t), .lrck_i(lrck_t), .sdata_i, .bclk_o, .lrck_o,
    .rd_i, .rdata_o, .dreq_o, .ovf_o, .ovf_irq_o
  );

  int n_cmp = 0, n_err = 0, irq_cnt = 0;
  logic mon_en = 1'b1;
  string cur_req = "R11";
  logic [31:0] exp_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  always @(posedge clk) if (rst_n && ovf_irq_o) irq_cnt++;

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && dreq_o) begin
        if (exp_q.size() == 0) check({cur_req, " unexpected word"}, rdata_o, 32'hxxxx_xxxx);
        else check(cur_req, rdata_o, exp_q.pop_front());
        rd_i = 1'b1;
      end else rd_i = 1'b0;
    end
  end

  // codec model for master mode
  logic bprev = 0, lprev = 1;
  int bpos = 0, fidx = -1;
  function automatic logic [23:0] mval(input int f, input logic lr);
    return 24'(f * 32'h0003A5C7 + (lr ? 32'h00E1D2C3 : 32'h004B1F6A));
  endfunction
  always @(negedge clk) begin
    if (bprev && !bclk_o) begin
      if (lrck_o != lprev) begin
        bpos = 0;
        if (!lrck_o) fidx++;
      end else bpos++;
      lprev = lrck_o;
      codec_bit = (bpos >= 1 && bpos <= 24) ? mval(fidx, lrck_o)[24-bpos] : 1'b0;
    end
    bprev = bclk_o;
  end

  function automatic logic [23:0] sv(input int k);
    return 24'(k * 32'h0013579B + 32'h00ABCDEF);
  endfunction

  task automatic bit_cyc(input logic lr, input logic [2:0] d);
    bclk_t = 0; lrck_t = lr; dat_t = d;
    repeat (4) @(negedge clk);
    bclk_t = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic slot(input logic lr, input logic [71:0] v);
    for (int b = 0; b < 32; b++) begin
      logic [2:0] d;
      for (int p = 0; p < 3; p++) d[p] = (b >= 1 && b <= 24) ? v[p*24 + 24 - b] : 1'b0;
      bit_cyc(lr, d);
    end
  endtask

  task automatic expect_frame(input logic [71:0] l, input logic [71:0] r);
    int np = (pairs_i == 0) ? 1 : int'(pairs_i);
    int w = int'(width_i);
    if (!wide_i) begin
      for (int p = 0; p < np; p++) exp_q.push_back({r[p*24+8 +: 16], l[p*24+8 +: 16]});
    end else begin
      for (int p = 0; p < np; p++) exp_q.push_back(32'(l[p*24 +: 24] >> (24 - w)));
      for (int p = 0; p < np; p++) exp_q.push_back(32'(r[p*24 +: 24] >> (24 - w)));
    end
  endtask

  task automatic frame(input int k, input logic do_exp);
    logic [71:0] l = {sv(6*k+2), sv(6*k+1), sv(6*k)};
    logic [71:0] r = {sv(6*k+5), sv(6*k+4), sv(6*k+3)};
    if (do_exp) expect_frame(l, r);
    slot(1'b0, l);
    slot(1'b1, r);
  endtask

  task automatic finish_run();
    run_i = 0;
    bit_cyc(1'b0, 3'b000);
  endtask

  task automatic drain(input string tag);
    repeat (60) @(negedge clk);
    check({tag, " queue drained"}, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 dreq", 32'(dreq_o), 0);
    check("R11 ovf", 32'(ovf_o), 0);
    check("R11 irq", 32'(ovf_irq_o), 0);
    check("R11 bclk", 32'(bclk_o), 0);
    check("R11 lrck", 32'(lrck_o), 1);

    // R10: slave, no clocks
    cur_req = "R10";
    run_i = 1;
    repeat (300) @(negedge clk);
    check("R10 no words", 32'(dreq_o), 0);

    // R1 R2 R3: garbage left/right before first left boundary
    cur_req = "R1 R2 R3";
    slot(1'b0, 72'hFFFFFF_FFFFFF_FFFFFF);
    slot(1'b1, 72'hA5A5A5_A5A5A5_A5A5A5);
    for (int k = 0; k < 3; k++) frame(k, 1'b1);
    finish_run();
    drain("R1");

    // R4: wide, width 20
    cur_req = "R4";
    wide_i = 1; width_i = 5'd20;
    run_i = 1;
    slot(1'b1, '0);
    for (int k = 3; k < 5; k++) frame(k, 1'b1);
    finish_run();
    drain("R4");

    // R5: three pairs wide 24, then two pairs packed
    cur_req = "R5";
    width_i = 5'd24; pairs_i = 2'd3;
    run_i = 1;
    slot(1'b1, '0);
    for (int k = 5; k < 7; k++) frame(k, 1'b1);
    finish_run();
    drain("R5");
    wide_i = 0; pairs_i = 2'd2;
    run_i = 1;
    slot(1'b1, '0);
    for (int k = 7; k < 9; k++) frame(k, 1'b1);
    finish_run();
    drain("R5");

    // R8: stop requested ten bits into the second frame
    cur_req = "R8";
    pairs_i = 2'd1;
    run_i = 1;
    fork
      begin
        slot(1'b1, '0);
        frame(9, 1'b1);
        frame(10, 1'b1);
        frame(11, 1'b0);
        bit_cyc(1'b0, 3'b000);
      end
      begin
        repeat (256 + 512 + 80) @(negedge clk);
        run_i = 0;
      end
    join
    drain("R8");

    // R6 R7: overflow with reader held off
    cur_req = "R6";
    mon_en = 0;
    wide_i = 1; width_i = 5'd24; pairs_i = 2'd3;
    irq_cnt = 0;
    run_i = 1;
    slot(1'b1, '0);
    frame(12, 1'b1);
    frame(13, 1'b1);
    finish_run();
    while (exp_q.size() > 8) void'(exp_q.pop_back());
    repeat (20) @(negedge clk);
    check("R7 dreq while full", 32'(dreq_o), 1);
    check("R6 sticky flag", 32'(ovf_o), 1);
    check("R6 drop pulses", 32'(irq_cnt), 4);
    mon_en = 1;
    drain("R6");
    check("R7 dreq after drain", 32'(dreq_o), 0);
    run_i = 1;
    repeat (2) @(negedge clk);
    check("R6 flag cleared on new run", 32'(ovf_o), 0);
    run_i = 0;
    repeat (4) @(negedge clk);

    // R9: master mode
    cur_req = "R9";
    wide_i = 0; pairs_i = 2'd1;
    master_i = 1;
    for (int f = 0; f < 3; f++) expect_frame(72'(mval(f, 1'b0)), 72'(mval(f, 1'b1)));
    run_i = 1;
    begin
      int t = 0, t1 = 0, t2 = 0, rises = 0;
      logic pb = 0;
      while (lrck_o) begin
        @(negedge clk);
        t++;
        if (bclk_o && !pb) begin
          rises++;
          if (rises == 1) t1 = t;
          if (rises == 2) t2 = t;
        end
        pb = bclk_o;
      end
      check("R9 bclk period", 32'(t2 - t1), 32'd8);
      check("R9 rises before left", 32'(rises), 32'd32);
    end
    while (!(fidx == 2 && !lrck_o)) @(negedge clk);
    repeat (40) @(negedge clk);
    cur_req = "R9 R8";
    run_i = 0;
    repeat (600) @(negedge clk);
    check("R8 bclk rests low", 32'(bclk_o), 0);
    check("R8 lrck rests high", 32'(lrck_o), 1);
    drain("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog (%s): actual running expected done", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule